// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block is the arithmetic part of an integer execute stage. It forms a 32-bit result from two operands with one of six operations: plain add, add with carry, subtract, subtract with carry, and the two reverse forms that take the second operand minus the first. The result is combinational. The block also holds a status word whose top four bits are the condition flags: negative, zero, carry and overflow, from the most significant bit down. The carry flag held there is the carry input for the with-carry operations.

The status word only changes on a clock edge where the commit input is high and flag setting is requested. When flag setting is requested and the destination is the program counter, no flags are computed. The whole status word is loaded from the saved-status input instead. All subtract forms store the inverse of the borrow in the carry flag.

Top module: `addsub_flag_unit`

## Requirements
- R1: On a flag update, status bit 31 (N) takes bit 31 of the result.
- R2: On a flag update, status bit 30 (Z) is 1 exactly when all 32 result bits are zero.
- R3: Opcode 0 (add) gives A+B and opcode 3 (add with carry) gives A+B+C. Status bit 29 (C) takes the carry out of bit 31.
- R4: Opcode 1 (subtract) gives A-B and opcode 4 (subtract with carry) gives A-B-NOT(C). In both, C becomes 1 when no borrow occurs.
- R5: Opcode 2 (reverse subtract) gives B-A and opcode 5 (reverse with carry) gives B-A-NOT(C). Carry is handled as in R4.
- R6: On a flag update, status bit 28 (V) is the signed overflow of the operation actually performed, including the carry term.
- R7: With commit, set-flags and destination-is-PC all high, the next status word equals the saved-status input.
- R8: With commit high and set-flags low, the status word does not change.
- R9: With commit low, the status word does not change, whatever the other inputs are.
- R10: An active-low reset clears the whole status word to zero.
- R11: Opcodes 6 and 7 give a zero result and leave the status word unchanged unless R7 applies.
- R12: A flag update leaves status bits 27..0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit_i | input | 1 | Qualifies a status update on this edge |
| op_i | input | 3 | Operation code (0..5, 6 and 7 reserved) |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second (shifted) operand |
| set_flags_i | input | 1 | Request a flag update |
| dest_pc_i | input | 1 | Destination is the program counter |
| saved_stat_i | input | 32 | Saved status word to restore |
| result_o | output | 32 | Arithmetic result (combinational) |
| stat_o | output | 32 | Registered status word, flags in bits 31..28 |

## Verification
The bench builds the block at its default 32-bit data and status widths. At these widths the extreme values 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF fall exactly on the signed and unsigned wrap points. Every operation is crossed with these values and with both states of the incoming carry, which reaches every carry, borrow and overflow boundary, including the with-carry terms that cause or prevent a wrap. Random operands, restore, hold, reserved-opcode and mid-run reset sequences then run against an independent wide-integer model.

// File: rtl/asu_pkg.sv
package asu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_RSB = 3'd2,
    OP_ADC = 3'd3,
    OP_SBC = 3'd4,
    OP_RSC = 3'd5
  } asu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } asu_flags_t;

  localparam int unsigned FLAG_W = $bits(asu_flags_t);

endpackage

// File: rtl/asu_adder.sv
module asu_adder
  import asu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf,
  output logic         op_ok
);

  logic         swap;
  logic         invert;
  logic         cin;
  logic [W-1:0] x;
  logic [W-1:0] y;
  logic [W-1:0] y_eff;
  logic [W:0]   full;

  // Decode the operation into swap / invert / carry-in controls
  always_comb begin
    swap   = 1'b0;
    invert = 1'b0;
    cin    = 1'b0;
    op_ok  = 1'b1;
    case (op)
      OP_ADD: begin end
      OP_ADC: cin = carry_in;
      OP_SUB: begin invert = 1'b1; cin = 1'b1; end
      OP_RSB: begin invert = 1'b1; cin = 1'b1; swap = 1'b1; end
      OP_SBC: begin invert = 1'b1; cin = carry_in; end
      OP_RSC: begin invert = 1'b1; cin = carry_in; swap = 1'b1; end
      default: op_ok = 1'b0;
    endcase
  end

  // One shared W+1 bit adder for every operation
  always_comb begin
    x     = swap ? b : a;
    y     = swap ? a : b;
    y_eff = invert ? ~y : y;
    full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, cin};
    sum   = op_ok ? full[W-1:0] : '0;
    cout  = op_ok & full[W];
    ovf   = op_ok & (x[W-1] == y_eff[W-1]) & (full[W-1] != x[W-1]);
  end

endmodule

// File: rtl/asu_flag_gen.sv
module asu_flag_gen
  import asu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] sum,
  input  logic         cout,
  input  logic         ovf,
  output asu_flags_t   flags
);

  always_comb begin
    flags.n = sum[W-1];
    flags.z = (sum == '0);
    flags.c = cout;
    flags.v = ovf;
  end

endmodule

// File: rtl/asu_status_reg.sv
module asu_status_reg
  import asu_pkg::*;
#(
  parameter int unsigned SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          set_flags,
  input  logic          dest_pc,
  input  logic          op_ok,
  input  asu_flags_t    flags_new,
  input  logic [SW-1:0] saved,
  output logic [SW-1:0] stat_q
);

  localparam int unsigned FTOP = SW - 1;
  localparam int unsigned REST = SW - FLAG_W;

  logic          upd_en;
  logic [SW-1:0] stat_d;

  assign upd_en = commit & set_flags;

  // Next-state selection
  always_comb begin
    stat_d = stat_q;
    if (dest_pc) begin
      stat_d = saved;
    end else if (op_ok) begin
      stat_d[FTOP -: FLAG_W] = flags_new;
    end
  end

  // Status register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (upd_en) begin
      stat_q <= stat_d;
    end
  end

  a_r9_no_commit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(stat_q));

  a_r8_no_set_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !set_flags) |=> $stable(stat_q));

  a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && set_flags && dest_pc) |=> (stat_q == $past(saved)));

  a_r12_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && set_flags && !dest_pc) |=> (stat_q[REST-1:0] == $past(stat_q[REST-1:0])));

  a_r11_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && set_flags && !dest_pc && !op_ok) |=> $stable(stat_q));

endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
  import asu_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_i,
  input  logic [2:0]    op_i,
  input  logic [W-1:0]  opa_i,
  input  logic [W-1:0]  opb_i,
  input  logic          set_flags_i,
  input  logic          dest_pc_i,
  input  logic [SW-1:0] saved_stat_i,
  output logic [W-1:0]  result_o,
  output logic [SW-1:0] stat_o
);

  localparam int unsigned N_POS = SW - 1;
  localparam int unsigned Z_POS = SW - 2;
  localparam int unsigned C_POS = SW - 3;

  logic       cout;
  logic       ovf;
  logic       op_ok;
  asu_flags_t flags_new;

  asu_adder #(.W(W)) u_adder (
    .op       (op_i),
    .a        (opa_i),
    .b        (opb_i),
    .carry_in (stat_o[C_POS]),
    .sum      (result_o),
    .cout     (cout),
    .ovf      (ovf),
    .op_ok    (op_ok)
  );

  asu_flag_gen #(.W(W)) u_flags (
    .sum   (result_o),
    .cout  (cout),
    .ovf   (ovf),
    .flags (flags_new)
  );

  asu_status_reg #(.SW(SW)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit_i),
    .set_flags (set_flags_i),
    .dest_pc   (dest_pc_i),
    .op_ok     (op_ok),
    .flags_new (flags_new),
    .saved     (saved_stat_i),
    .stat_q    (stat_o)
  );

  a_r1_negative: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && set_flags_i && !dest_pc_i && op_ok) |=> (stat_o[N_POS] == $past(result_o[W-1])));

  a_r2_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && set_flags_i && !dest_pc_i && op_ok) |=> (stat_o[Z_POS] == ($past(result_o) == '0)));

  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > 3'd5) |-> (result_o == '0));

endmodule

// File: tb/test_addsub_flag_unit.sv
`timescale 1ns/1ps
module test_addsub_flag_unit;

  typedef struct {
    logic [31:0] stat;
    string       tag;
  } exp_item_t;

  logic        clk;
  logic        rst_n;
  logic        commit_i;
  logic [2:0]  op_i;
  logic [31:0] opa_i;
  logic [31:0] opb_i;
  logic        set_flags_i;
  logic        dest_pc_i;
  logic [31:0] saved_stat_i;
  logic [31:0] result_o;
  logic [31:0] stat_o;

  int          n_checks = 0;
  int          n_fails  = 0;
  logic [31:0] exp_stat;
  exp_item_t   sb_q[$];

  addsub_flag_unit i_addsub_flag_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_i     (commit_i),
    .op_i         (op_i),
    .opa_i        (opa_i),
    .opb_i        (opb_i),
    .set_flags_i  (set_flags_i),
    .dest_pc_i    (dest_pc_i),
    .saved_stat_i (saved_stat_i),
    .result_o     (result_o),
    .stat_o       (stat_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Wide-integer reference model
  task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic c, output logic [31:0] r, output logic [3:0] f);
    longint ua, ub, sa, sb, u, s, cc;
    logic   cy;
    ua = longint'({32'd0, a});
    ub = longint'({32'd0, b});
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    cc = c ? 1 : 0;
    u = 0; s = 0; cy = 1'b0;
    case (op)
      3'd0: begin u = ua + ub;            s = sa + sb;            cy = (u > 64'sd4294967295); end
      3'd3: begin u = ua + ub + cc;       s = sa + sb + cc;       cy = (u > 64'sd4294967295); end
      3'd1: begin u = ua - ub;            s = sa - sb;            cy = (u >= 0); end
      3'd4: begin u = ua - ub - (1 - cc); s = sa - sb - (1 - cc); cy = (u >= 0); end
      3'd2: begin u = ub - ua;            s = sb - sa;            cy = (u >= 0); end
      3'd5: begin u = ub - ua - (1 - cc); s = sb - sa - (1 - cc); cy = (u >= 0); end
      default: begin u = 0; s = 0; cy = 1'b0; end
    endcase
    r = u[31:0];
    f[3] = r[31];
    f[2] = (r == 32'd0);
    f[1] = cy;
    f[0] = (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endtask

  // Driver: applies one operation and queues the expected status word
  task automatic drive(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic set, input logic pc, input logic com, input logic [31:0] saved);
    logic [31:0] r;
    logic [3:0]  f;
    logic [31:0] nxt;
    string       otag;
    exp_item_t   it;
    @(negedge clk);
    op_i = op; opa_i = a; opb_i = b;
    set_flags_i = set; dest_pc_i = pc; commit_i = com; saved_stat_i = saved;
    #1;
    model(op, a, b, exp_stat[29], r, f);
    case (op)
      3'd0, 3'd3: otag = "R3";
      3'd1, 3'd4: otag = "R4";
      3'd2, 3'd5: otag = "R5";
      default:    otag = "R11";
    endcase
    chk({otag, " result"}, result_o, (op < 3'd6) ? r : 32'd0);
    nxt = exp_stat;
    if (!com)            it.tag = "R9 hold";
    else if (!set)       it.tag = "R8 hold";
    else if (pc)         it.tag = "R7 restore";
    else if (op > 3'd5)  it.tag = "R11 hold";
    else                 it.tag = {"R1 R2 R6 R12 status ", otag};
    if (com && set) begin
      if (pc)             nxt = saved;
      else if (op < 3'd6) nxt = {f, exp_stat[27:0]};
    end
    it.stat = nxt;
    sb_q.push_back(it);
    exp_stat = nxt;
  endtask

  // Monitor: compares the registered status after each edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      chk(it.tag, stat_o, it.stat);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  logic [31:0] corner [4];

  initial begin
    corner[0] = 32'h0000_0000;
    corner[1] = 32'h7FFF_FFFF;
    corner[2] = 32'h8000_0000;
    corner[3] = 32'hFFFF_FFFF;
    rst_n = 1'b0; commit_i = 1'b0; op_i = 3'd0; opa_i = '0; opb_i = '0;
    set_flags_i = 1'b0; dest_pc_i = 1'b0; saved_stat_i = '0;
    exp_stat = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset", stat_o, 32'd0);
    rst_n = 1'b1;

    // Restore a status word with low bits set, C=0
    drive(3'd0, 0, 0, 1, 1, 1, 32'h0AB_CDE5);
    // Corner crossing, each op with C cleared and with C set
    for (int op = 0; op < 6; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int cs = 0; cs < 2; cs++) begin
            drive(3'd0, 0, 0, 1, 1, 1, {2'b00, cs[0], 1'b0, 28'h1234567});
            drive(op[2:0], corner[i], corner[j], 1, 0, 1, 32'd0);
          end

    // Small-value carry edges for with-carry forms
    drive(3'd0, 0, 0, 1, 1, 1, 32'h2000_0000);
    drive(3'd4, 32'd5, 32'd5, 1, 0, 1, 0);
    drive(3'd0, 0, 0, 1, 1, 1, 32'h0000_0000);
    drive(3'd4, 32'd5, 32'd5, 1, 0, 1, 0);
    drive(3'd0, 0, 0, 1, 1, 1, 32'h0000_0000);
    drive(3'd5, 32'd3, 32'd4, 1, 0, 1, 0);

    // Holds: no set, no commit, reserved opcodes
    drive(3'd1, 32'd1, 32'd2, 0, 0, 1, 32'hFFFF_FFFF);
    drive(3'd1, 32'd1, 32'd2, 1, 0, 0, 32'hFFFF_FFFF);
    drive(3'd1, 32'd1, 32'd2, 1, 1, 0, 32'hFFFF_FFFF);
    drive(3'd6, 32'd9, 32'd1, 1, 0, 1, 32'hFFFF_FFFF);
    drive(3'd7, 32'hFFFF_FFFF, 32'd1, 1, 0, 1, 0);
    drive(3'd7, 32'd1, 32'd1, 1, 1, 1, 32'h5000_00A5);

    // Random traffic
    for (int k = 0; k < 600; k++) begin
      logic [2:0] rop;
      rop = 3'($urandom_range(0, 7));
      drive(rop, $urandom, $urandom, ($urandom_range(0, 3) != 0),
            ($urandom_range(0, 9) == 0), ($urandom_range(0, 7) != 0), $urandom);
    end

    // Mid-run asynchronous reset
    drive(3'd0, 0, 0, 1, 1, 1, 32'hF000_000F);
    @(negedge clk);
    commit_i = 1'b0;
    #1 rst_n = 1'b0;
    #1 chk("R10 async reset", stat_o, 32'd0);
    exp_stat = '0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(3'd1, 32'd7, 32'd7, 1, 0, 1, 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule